// File: doc/BRIEF.md
# Byte-Loaded Serial Avionics Word Transmitter

This block turns four 8-bit host writes into one 32-bit serial word on an ARINC 429 line and keeps a four-bit-period quiet interval after every word. The host puts a byte on `host_data`, sets `first_byte` for the label byte, and pulses `wr_n` low. The block captures the byte when the strobe rises again. After the fourth byte the word is complete. `tx_ready` then drops and stays low until the serializer takes the word. A 32-bit holding buffer lets the next word be loaded while the current one shifts out.

The line side has two return-to-zero outputs, one for mark bits and one for space bits. It also has an NRZ serial data output and an active-low sync pulse on the eighth bit, for ARINC 561 receivers. All bit timing comes from `phase_tick`. This is a one-cycle pulse at each half-bit boundary and stands in for the transmit clock. The first half of every bit period is the clock-high half. Bit 32 can be replaced by an odd-parity bit.

Top module: `a429_byte_tx`

## Requirements
- R1: Byte n (n = 1..4) occupies word bits 8n-7..8n. Bit 1 is the first bit sent, and within each byte D0 is sent first.
- R2: A write with `first_byte` high stores the label byte and restarts the byte sequence. A write with `first_byte` low before any label write is ignored.
- R3: `wr_n` passes through two synchronizer flops before use. A byte is taken on the third rising clock edge that samples `wr_n` high after a low pulse.
- R4: `tx_ready` is high while the holding buffer is not full and goes low once byte 4 is stored. Writes made while it is low are ignored.
- R5: Every word is followed by exactly 4 bit periods in which both RZ outputs and the 561 data output stay low and sync stays high.
- R6: A complete buffered word moves into the serializer at the boundary that starts the 4th gap bit. `tx_ready` returns high on that boundary, and the new word begins with no extra gap.
- R7: When the word completes after that point, or while the line is idle, the word moves in at the next bit boundary and its bit 1 starts there.
- R8: With `odd_par_en` high when the word is taken, bit 32 makes the count of ones in the word odd. With it low, bit 32 is D7 of byte 4.
- R9: `one_rz` is high for a 1 bit and `zero_rz` is high for a 0 bit, each only during the first half of the bit period.
- R10: `s561_data` shows the current bit for the whole bit period and is low outside data bits.
- R11: `s561_sync_n` is low only during the second half of word bit 8.
- R12: After reset, `tx_ready` is high and the line shows a continuous gap until a word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_tick | input | 1 | One-cycle pulse at each half-bit boundary |
| host_data | input | 8 | Byte to load |
| first_byte | input | 1 | High for the label byte |
| wr_n | input | 1 | Active-low write strobe; the byte is taken at its rising end |
| odd_par_en | input | 1 | Replaces bit 32 with odd parity |
| tx_ready | output | 1 | High while the holding buffer can take a word |
| one_rz | output | 1 | RZ pulse for a 1 bit |
| zero_rz | output | 1 | RZ pulse for a 0 bit |
| s561_data | output | 1 | NRZ serial data |
| s561_sync_n | output | 1 | Active-low pulse in the second half of bit 8 |

## Verification
The hardest case to reach from the ports is the handoff at the start of the fourth gap bit. The next word has to be complete before the first word's data ends, so the serializer takes it early and starts it with no extra gap. The bench reaches this by loading a second word while the first is still shifting out. It also covers the late case: a word completed during the last gap bit or while the line is idle must start at the very next boundary. A bench-side model tracks synchronizer latency, buffer fill and the bit schedule, and compares every output on every cycle.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  // Which half of a bit period the transmitter is in.
  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;
endpackage

// File: rtl/a429_host_load.sv
module a429_host_load #(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 4,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = BYTE_W * NUM_BYTES,
  localparam int CNT_W      = $clog2(NUM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              first_byte,
  input  logic [BYTE_W-1:0] din,
  input  logic              take,
  output logic              word_full,
  output logic [WORD_W-1:0] word_buf
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NUM_BYTES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   wr_pulse;
  logic                   wr_ok;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic                   full_q, full_d;
  logic [NUM_BYTES-1:0]   lane_we;

  // Strobe synchronizer and rising-edge detect; idle level is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], wr_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign wr_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
  assign wr_ok    = wr_pulse & ~full_q;

  // Byte sequence: count 0 means no label byte seen yet.
  always_comb begin
    cnt_d  = cnt_q;
    full_d = full_q;
    if (wr_ok) begin
      if (first_byte) begin
        cnt_d = CNT_W'(1);
      end else if (cnt_q != '0) begin
        if (cnt_q == CNT_LAST) begin
          cnt_d  = '0;
          full_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
    if (take) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
    end
  end

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    if (g == 0) begin : g_label
      assign lane_we[g] = wr_ok & first_byte;
    end else begin : g_body
      assign lane_we[g] = wr_ok & ~first_byte & (cnt_q == CNT_W'(g));
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_buf[g*BYTE_W +: BYTE_W] <= '0;
      end else if (lane_we[g]) begin
        word_buf[g*BYTE_W +: BYTE_W] <= din;
      end
    end
  end

  assign word_full = full_q;

  // R4: a full buffer stays full until the serializer takes it.
  p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !take |=> full_q);
  // R4: the buffer only becomes full on an accepted strobe edge.
  p_fill_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q ##1 full_q |-> $past(wr_pulse));
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
  import a429_tx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int GAP_BITS  = 4,
  localparam int SLOTS    = WORD_BITS + GAP_BITS,
  localparam int SLOT_W   = $clog2(SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phase_tick,
  input  logic                 odd_par_en,
  input  logic                 word_full,
  input  logic [WORD_BITS-1:0] word_buf,
  output logic                 take,
  output half_e                phase_q,
  output logic                 active_q,
  output logic [SLOT_W-1:0]    slot_q,
  output logic                 cur_bit
);
  // GAP_BITS must be at least 2 so the early handoff slot lies in the gap.
  localparam logic [SLOT_W-1:0] SLOT_END  = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_PRE  = SLOT_W'(SLOTS - 2);
  localparam logic [SLOT_W-1:0] SLOT_DATA = SLOT_W'(WORD_BITS);

  half_e                phase_d;
  logic                 active_d, loaded_q, loaded_d;
  logic [SLOT_W-1:0]    slot_d;
  logic [WORD_BITS-1:0] sh_q, sh_d, load_word;
  logic                 boundary, slot_ok, par_bit;

  assign boundary  = phase_tick & (phase_q == HALF_SECOND);
  assign slot_ok   = !active_q || (slot_q == SLOT_PRE) || (slot_q == SLOT_END);
  assign take      = boundary & word_full & ~loaded_q & slot_ok;
  assign par_bit   = odd_par_en ? ~(^word_buf[WORD_BITS-2:0]) : word_buf[WORD_BITS-1];
  assign load_word = {par_bit, word_buf[WORD_BITS-2:0]};

  always_comb begin
    phase_d  = phase_tick ? half_e'(~phase_q) : phase_q;
    active_d = active_q;
    slot_d   = slot_q;
    sh_d     = sh_q;
    loaded_d = loaded_q;
    if (boundary) begin
      if (!active_q) begin
        if (take) begin
          active_d = 1'b1;
          slot_d   = '0;
          sh_d     = load_word;
        end
      end else if (slot_q == SLOT_END) begin
        slot_d = '0;
        if (loaded_q) begin
          loaded_d = 1'b0;
        end else if (take) begin
          sh_d = load_word;
        end else begin
          active_d = 1'b0;
        end
      end else begin
        slot_d = slot_q + 1'b1;
        if (slot_q < SLOT_DATA) sh_d = sh_q >> 1;
        if (take) begin
          sh_d     = load_word;
          loaded_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= HALF_FIRST;
      active_q <= 1'b0;
      slot_q   <= '0;
      sh_q     <= '0;
      loaded_q <= 1'b0;
    end else begin
      phase_q  <= phase_d;
      active_q <= active_d;
      slot_q   <= slot_d;
      sh_q     <= sh_d;
      loaded_q <= loaded_d;
    end
  end

  assign cur_bit = sh_q[0];

  // R5: within a word, slots advance by one per bit boundary.
  p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && boundary && (slot_q != SLOT_END) |=> slot_q == $past(slot_q) + 1'b1);
  // R6: an early-loaded word waits only in the last gap slot.
  p_loaded_in_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> active_q && (slot_q == SLOT_END));
  // R7: a word always starts at bit 1.
  p_start_bit1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> slot_q == '0);
endmodule

// File: rtl/a429_line_out.sv
module a429_line_out
  import a429_tx_pkg::*;
#(
  parameter int WORD_BITS = 32,
  parameter int SYNC_BIT  = 8,
  parameter int SLOT_W    = 6
) (
  input  logic              active,
  input  logic [SLOT_W-1:0] slot,
  input  half_e             phase,
  input  logic              cur_bit,
  output logic              one_rz,
  output logic              zero_rz,
  output logic              s561_data,
  output logic              s561_sync_n
);
  localparam logic [SLOT_W-1:0] SLOT_DATA = SLOT_W'(WORD_BITS);
  localparam logic [SLOT_W-1:0] SLOT_SYNC = SLOT_W'(SYNC_BIT - 1);

  logic in_data, first_half;

  assign in_data     = active && (slot < SLOT_DATA);
  assign first_half  = (phase == HALF_FIRST);
  assign one_rz      = in_data & first_half & cur_bit;
  assign zero_rz     = in_data & first_half & ~cur_bit;
  assign s561_data   = in_data & cur_bit;
  assign s561_sync_n = ~(in_data & ~first_half & (slot == SLOT_SYNC));
endmodule

// File: rtl/a429_byte_tx.sv
module a429_byte_tx
  import a429_tx_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 4,
  parameter int GAP_BITS    = 4,
  parameter int SYNC_BIT    = 8,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_BITS  = BYTE_W * NUM_BYTES,
  localparam int SLOT_W     = $clog2(WORD_BITS + GAP_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_tick,
  input  logic [BYTE_W-1:0] host_data,
  input  logic              first_byte,
  input  logic              wr_n,
  input  logic              odd_par_en,
  output logic              tx_ready,
  output logic              one_rz,
  output logic              zero_rz,
  output logic              s561_data,
  output logic              s561_sync_n
);
  logic                 word_full, take, active, cur_bit;
  logic [WORD_BITS-1:0] word_buf;
  logic [SLOT_W-1:0]    slot;
  half_e                phase;

  a429_host_load #(
    .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SYNC_STAGES(SYNC_STAGES)
  ) u_load (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .first_byte(first_byte),
    .din(host_data), .take(take), .word_full(word_full), .word_buf(word_buf)
  );

  a429_tx_seq #(
    .WORD_BITS(WORD_BITS), .GAP_BITS(GAP_BITS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .odd_par_en(odd_par_en),
    .word_full(word_full), .word_buf(word_buf), .take(take), .phase_q(phase),
    .active_q(active), .slot_q(slot), .cur_bit(cur_bit)
  );

  a429_line_out #(
    .WORD_BITS(WORD_BITS), .SYNC_BIT(SYNC_BIT), .SLOT_W(SLOT_W)
  ) u_line (
    .active(active), .slot(slot), .phase(phase), .cur_bit(cur_bit),
    .one_rz(one_rz), .zero_rz(zero_rz), .s561_data(s561_data),
    .s561_sync_n(s561_sync_n)
  );

  assign tx_ready = ~word_full;

  // R9: RZ pulses appear only in the first half of a bit period.
  p_rz_first_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == HALF_SECOND) |-> !one_rz && !zero_rz);
  // R5: idle and gap slots keep the line quiet.
  p_quiet_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active || slot >= SLOT_W'(WORD_BITS)) |-> !one_rz && !zero_rz && !s561_data && s561_sync_n);
  // R11: sync pulse only in the second half of bit 8.
  p_sync_bit8_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !s561_sync_n |-> active && (slot == SLOT_W'(SYNC_BIT - 1)) && (phase == HALF_SECOND));
  // R6: the host sees ready right after the serializer takes the word.
  p_ready_after_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> tx_ready);
endmodule

// File: tb/a429_byte_tx_test.sv
`timescale 1ns/1ps
module a429_byte_tx_test;
  localparam int HALF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_tick = 1'b0;
  logic [7:0] host_data = 8'h00;
  logic first_byte = 1'b0;
  logic wr_n = 1'b1;
  logic odd_par_en = 1'b0;
  logic tx_ready, one_rz, zero_rz, s561_data, s561_sync_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_tag = "R12";

  always #5 clk = ~clk;

  a429_byte_tx uut (
    .clk(clk), .rst_n(rst_n), .phase_tick(phase_tick), .host_data(host_data),
    .first_byte(first_byte), .wr_n(wr_n), .odd_par_en(odd_par_en),
    .tx_ready(tx_ready), .one_rz(one_rz), .zero_rz(zero_rz),
    .s561_data(s561_data), .s561_sync_n(s561_sync_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Half-bit tick source.
  int tick_cnt = 0;
  always @(negedge clk) begin
    if (tick_cnt == HALF - 1) begin
      tick_cnt   <= 0;
      phase_tick <= 1'b1;
    end else begin
      tick_cnt   <= tick_cnt + 1;
      phase_tick <= 1'b0;
    end
  end

  // Behavioural reference: strobe latency, byte filling, bit schedule.
  int m_w1, m_w2, m_wp, m_cnt, m_slot;
  bit [31:0] m_buf, m_sh;
  bit m_full, m_ph, m_act, m_ld;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_w1 = 1; m_w2 = 1; m_wp = 1; m_cnt = 0; m_slot = 0;
      m_buf = 0; m_sh = 0; m_full = 0; m_ph = 0; m_act = 0; m_ld = 0;
    end else begin
      bit pulse, bnd, tk, old_full;
      bit [31:0] w;
      pulse = (m_w2 == 1) && (m_wp == 0);
      bnd = phase_tick && m_ph;
      old_full = m_full;
      tk = bnd && m_full && !m_ld && (!m_act || m_slot == 34 || m_slot == 35);
      w = m_buf;
      if (odd_par_en) w[31] = ~(^m_buf[30:0]);
      if (pulse && !old_full) begin
        if (first_byte) begin
          m_buf[7:0] = host_data; m_cnt = 1;
        end else if (m_cnt != 0) begin
          m_buf[m_cnt*8 +: 8] = host_data;
          if (m_cnt == 3) begin m_full = 1; m_cnt = 0; end
          else m_cnt = m_cnt + 1;
        end
      end
      if (tk) m_full = 0;
      if (bnd) begin
        if (!m_act) begin
          if (tk) begin m_act = 1; m_slot = 0; m_sh = w; end
        end else if (m_slot == 35) begin
          m_slot = 0;
          if (m_ld) m_ld = 0;
          else if (tk) m_sh = w;
          else m_act = 0;
        end else begin
          if (m_slot < 32) m_sh = m_sh >> 1;
          m_slot = m_slot + 1;
          if (tk) begin m_sh = w; m_ld = 1; end
        end
      end
      m_wp = m_w2; m_w2 = m_w1; m_w1 = int'(wr_n);
      if (phase_tick) m_ph = ~m_ph;
    end
  end

  // Compare every output on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      bit dat, e_hi, e_lo, e_d, e_s;
      dat  = m_act && (m_slot < 32);
      e_hi = dat && !m_ph && m_sh[0];
      e_lo = dat && !m_ph && !m_sh[0];
      e_d  = dat && m_sh[0];
      e_s  = !(dat && m_slot == 7 && m_ph);
      chk(one_rz == e_hi && zero_rz == e_lo, {"R9 rz ", cur_tag}, {one_rz, zero_rz}, {e_hi, e_lo});
      chk(s561_data == e_d, {"R10 data ", cur_tag}, s561_data, e_d);
      chk(s561_sync_n == e_s, {"R11 sync ", cur_tag}, s561_sync_n, e_s);
      chk(tx_ready == !m_full, {"R4 ready ", cur_tag}, tx_ready, !m_full);
    end
  end

  task automatic write_byte(input bit a0, input logic [7:0] d);
    @(negedge clk);
    host_data = d; first_byte = a0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic load_word(input logic [31:0] w);
    write_byte(1'b1, w[7:0]);
    write_byte(1'b0, w[15:8]);
    write_byte(1'b0, w[23:16]);
    write_byte(1'b0, w[31:24]);
  endtask

  task automatic wait_ready();
    while (!tx_ready) @(negedge clk);
  endtask

  task automatic wait_idle();
    repeat (40 * 2 * HALF) @(negedge clk);
  endtask

  // Watchdog: a hung run is a failed check and still prints the summary.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12: reset state shows a quiet line and a ready buffer.
    chk(tx_ready == 1'b1, "R12 ready after reset", tx_ready, 1);
    chk(!one_rz && !zero_rz && !s561_data && s561_sync_n, "R12 quiet line",
        {one_rz, zero_rz, s561_data, s561_sync_n}, 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R2: body bytes before any label are dropped.
    cur_tag = "R2";
    write_byte(1'b0, 8'hAA); write_byte(1'b0, 8'hBB);
    write_byte(1'b0, 8'hCC); write_byte(1'b0, 8'hDD);
    chk(tx_ready == 1'b1, "R2 no label ignored", tx_ready, 1);

    // R3: byte 4 taken on the third edge seeing the strobe high.
    cur_tag = "R3 R1 R8";
    odd_par_en = 1'b0;
    write_byte(1'b1, 8'h5A); write_byte(1'b0, 8'h0F); write_byte(1'b0, 8'hC3);
    @(negedge clk);
    host_data = 8'h96; first_byte = 1'b0; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R3 before capture", tx_ready, 1);
    @(negedge clk);
    chk(tx_ready == 1'b0, "R3 R4 after capture", tx_ready, 0);

    // R4: writes while full are ignored; R7: idle start at next boundary.
    cur_tag = "R4 R7";
    write_byte(1'b1, 8'hFF);
    wait_ready();
    // R6: next word loaded during transmission, handed off in the gap.
    cur_tag = "R6 R8 R5";
    odd_par_en = 1'b1;
    load_word(32'h1234_5678);
    wait_ready();
    load_word(32'h8000_0001);
    wait_ready();
    // R2: label rewrite restarts the sequence mid-word.
    cur_tag = "R2 R1";
    odd_par_en = 1'b0;
    write_byte(1'b1, 8'h11); write_byte(1'b0, 8'h22);
    write_byte(1'b1, 8'h81); write_byte(1'b0, 8'h42);
    write_byte(1'b0, 8'h24); write_byte(1'b0, 8'hE7);
    wait_ready();
    wait_idle();
    // R7: word completed while idle; parity on an all-ones word (R8).
    cur_tag = "R7 R8";
    odd_par_en = 1'b1;
    load_word(32'hFFFF_FFFF);
    wait_ready();
    // R5 R10: gap after the last word, then continuous idle.
    cur_tag = "R5 R10 R12";
    wait_idle();
    chk(!one_rz && !zero_rz && !s561_data, "R5 idle quiet",
        {one_rz, zero_rz, s561_data}, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule